// File: doc/BRIEF.md
# Dual-Slot Receive Frame Assembler

This block takes received Ethernet frames as a byte stream (destination address first, no preamble and no FCS) and rebuilds the complete on-wire image of each frame inside one of two receive slots of a byte-addressed buffer. Each slot holds up to `SLOT_BYTES` bytes and owns a two-bit state and a byte count. Software arms a slot by writing its state to "loaded". The block then fills the slot and hands it back by setting the state to "pending", which raises a level interrupt.

For every accepted frame the block writes the payload from byte 8 upward as it arrives. It zero-pads a short payload up to the minimum length and appends a CRC-32 frame check sequence computed over the padded payload. Last, it fills bytes 0 to 7 with the preamble and start delimiter. It then records the byte count and marks the slot pending in the same cycle. The upstream source watches `in_ready` to hold off frames while no slot is armed or while a stored frame is being finished.

Top module: `rx_slot_assembler`

## Requirements
- R1: After reset every slot state and count is 0, `rx_irq` is low and `in_ready` is low.
- R2: Slot state encoding is 0 = empty, 1 = loaded, 2 = pending, held in `slot_state[2s+1:2s]` for slot s. A software write (`sw_we`, `sw_slot`, `sw_state`) appears in that field one cycle later.
- R3: A frame starts at a byte with `in_valid` and `in_first`. It goes to the lowest-numbered slot whose state is 1 at that byte. If no slot is loaded, the frame is consumed up to its `in_last` byte and dropped, with no buffer write and no state change.
- R4: Buffer bytes 0 to 6 of the slot hold 0x55 and byte 7 holds 0xD5. The payload bytes sit from byte 8 upward in arrival order. The preamble bytes are the last eight writes of a frame, written at addresses 0 to 7 in order.
- R5: A payload shorter than 60 bytes is followed by zero bytes up to a length of 60. A payload of 60 bytes or more gets no padding.
- R6: The four FCS bytes follow the padded payload, least significant byte at the lowest address. The FCS is the reflected CRC-32 (polynomial 0x04C11DB7, seed all ones, final inversion) over the padded payload. The stored count is the padded length plus 12.
- R7: A payload of more than `SLOT_BYTES`-12 bytes is discarded. Buffer writes stop after `SLOT_BYTES`-12 payload bytes, the slot stays loaded, its count keeps its old value and no interrupt is raised. A payload of exactly `SLOT_BYTES`-12 bytes is stored with count `SLOT_BYTES`.
- R8: On completion the slot's count and its state value 2 are updated in the same cycle. `rx_irq` is high while at least one slot is pending.
- R9: A software state write that creates or removes the last pending slot changes `rx_irq` in the next cycle.
- R10: `in_ready` is high when at least one slot is loaded and no finished frame is still being padded, checked or given its preamble.
- R11: The buffer takes one write per cycle. A stored frame is committed exactly P+12 clock edges after the edge that accepts its last payload byte, where P is the number of pad bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload byte valid |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Source may present a frame |
| sw_we | input | 1 | Software write to a slot state |
| sw_slot | input | $clog2(NUM_SLOTS) | Slot addressed by the write |
| sw_state | input | 2 | State value written |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_slot | output | $clog2(NUM_SLOTS) | Slot being written |
| buf_addr | output | $clog2(SLOT_BYTES) | Byte offset within the slot |
| buf_wdata | output | 8 | Byte written |
| slot_state | output | 2*NUM_SLOTS | Per-slot state fields |
| slot_count | output | $clog2(SLOT_BYTES+1)*NUM_SLOTS | Per-slot stored byte counts |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
A wrong sequencer state shows up on the buffer write port within a cycle: a misplaced, missing or extra write is caught by comparing every write against a queue of expected slot, address and byte triples. A corrupted CRC register shows only in the four FCS writes, so each frame's check bytes are compared against a CRC computed separately in the bench. A wrong slot state or count shows on `slot_state`, `slot_count` and `rx_irq`. These are sampled one cycle before and one cycle after the predicted commit edge, so early, late or missing commits are all exposed.

// File: rtl/rxa_pkg.sv
`timescale 1ns/1ps
package rxa_pkg;
   localparam int PRE_LEN = 8;
   localparam int FCS_LEN = 4;
   localparam int SUB_W   = $clog2(PRE_LEN);

   localparam logic [7:0] PRE_FILL = 8'h55;
   localparam logic [7:0] PRE_SFD  = 8'hD5;

   localparam logic [1:0] SLOT_EMPTY   = 2'd0;
   localparam logic [1:0] SLOT_ARMED   = 2'd1;
   localparam logic [1:0] SLOT_PENDING = 2'd2;

   localparam logic [31:0] CRC_REFL_POLY = 32'hEDB88320;
   localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_BODY,
      SQ_SKIP,
      SQ_PAD,
      SQ_FCS,
      SQ_PRE
   } seq_t;

   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int b = 0; b < 8; b++) begin
         if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_REFL_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction
endpackage

// File: rtl/rxa_crc32.sv
`timescale 1ns/1ps
module rxa_crc32
   import rxa_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        restart,
   input  logic [7:0]  data,
   output logic [31:0] fcs
);
   logic [31:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  crc_q <= CRC_SEED;
      else if (en) crc_q <= crc32_step(restart ? CRC_SEED : crc_q, data);
   end

   assign fcs = ~crc_q;
endmodule

// File: rtl/rxa_slot_bank.sv
`timescale 1ns/1ps
module rxa_slot_bank
   import rxa_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int CW        = 12,
   parameter int SW        = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sw_we,
   input  logic [SW-1:0]           sw_slot,
   input  logic [1:0]              sw_state,
   input  logic                    commit,
   input  logic [SW-1:0]           commit_slot,
   input  logic [CW-1:0]           commit_count,
   output logic [2*NUM_SLOTS-1:0]  slot_state,
   output logic [CW*NUM_SLOTS-1:0] slot_count,
   output logic                    any_armed,
   output logic [SW-1:0]           first_armed,
   output logic                    irq
);
   logic [NUM_SLOTS-1:0] armed;
   logic [NUM_SLOTS-1:0] pend;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic [1:0]    st_q;
      logic [CW-1:0] cnt_q;

      // hardware completion wins over a same-cycle software write
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= SLOT_EMPTY;
            cnt_q <= '0;
         end else if (commit && commit_slot == SW'(i)) begin
            st_q  <= SLOT_PENDING;
            cnt_q <= commit_count;
         end else if (sw_we && sw_slot == SW'(i)) begin
            st_q  <= sw_state;
         end
      end

      assign slot_state[2*i +: 2]   = st_q;
      assign slot_count[CW*i +: CW] = cnt_q;
      assign armed[i] = (st_q == SLOT_ARMED);
      assign pend[i]  = (st_q == SLOT_PENDING);
   end

   always_comb begin
      first_armed = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (armed[i]) first_armed = SW'(i);
      end
   end

   assign any_armed = |armed;
   assign irq       = |pend;
endmodule

// File: rtl/rxa_seq.sv
`timescale 1ns/1ps
module rxa_seq
   import rxa_pkg::*;
#(
   parameter int SLOT_BYTES  = 2048,
   parameter int MIN_PAYLOAD = 60,
   parameter int SW          = 1,
   parameter int AW          = 11,
   parameter int CW          = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_first,
   input  logic          in_last,
   input  logic [7:0]    in_data,
   input  logic          any_armed,
   input  logic [SW-1:0] first_armed,
   input  logic [31:0]   fcs,
   output logic          in_ready,
   output logic          buf_we,
   output logic [SW-1:0] buf_slot,
   output logic [AW-1:0] buf_addr,
   output logic [7:0]    buf_wdata,
   output logic          crc_en,
   output logic          crc_restart,
   output logic [7:0]    crc_data,
   output logic          commit,
   output logic [SW-1:0] commit_slot,
   output logic [CW-1:0] commit_count
);
   localparam int            MAX_PAY   = SLOT_BYTES - PRE_LEN - FCS_LEN;
   localparam logic [CW-1:0] MAX_PAY_C = CW'(MAX_PAY);
   localparam logic [CW-1:0] MIN_C     = CW'(MIN_PAYLOAD);
   localparam logic [CW-1:0] ONE_C     = CW'(1);
   localparam logic [CW-1:0] TAIL_C    = CW'(PRE_LEN + FCS_LEN);
   localparam logic [AW-1:0] PRE_A     = AW'(PRE_LEN);

   seq_t             st, st_d;
   logic [CW-1:0]    cnt, cnt_d, cnt_inc;
   logic [SUB_W-1:0] sub, sub_d;
   logic [SW-1:0]    slot_q, slot_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         cnt    <= '0;
         sub    <= '0;
         slot_q <= '0;
      end else begin
         st     <= st_d;
         cnt    <= cnt_d;
         sub    <= sub_d;
         slot_q <= slot_d;
      end
   end

   assign cnt_inc = cnt + ONE_C;

   always_comb begin
      st_d        = st;
      cnt_d       = cnt;
      sub_d       = sub;
      slot_d      = slot_q;
      buf_we      = 1'b0;
      buf_addr    = '0;
      buf_wdata   = '0;
      crc_en      = 1'b0;
      crc_restart = 1'b0;
      crc_data    = in_data;
      commit      = 1'b0;
      case (st)
         SQ_IDLE: begin
            if (in_valid && in_first) begin
               if (any_armed) begin
                  buf_we      = 1'b1;
                  buf_addr    = PRE_A;
                  buf_wdata   = in_data;
                  crc_en      = 1'b1;
                  crc_restart = 1'b1;
                  slot_d      = first_armed;
                  cnt_d       = ONE_C;
                  sub_d       = '0;
                  if (in_last) st_d = (ONE_C < MIN_C) ? SQ_PAD : SQ_FCS;
                  else         st_d = SQ_BODY;
               end else if (!in_last) begin
                  st_d = SQ_SKIP;
               end
            end
         end
         SQ_BODY: begin
            if (in_valid) begin
               if (cnt == MAX_PAY_C) begin
                  st_d = in_last ? SQ_IDLE : SQ_SKIP;
               end else begin
                  buf_we    = 1'b1;
                  buf_addr  = PRE_A + cnt[AW-1:0];
                  buf_wdata = in_data;
                  crc_en    = 1'b1;
                  cnt_d     = cnt_inc;
                  if (in_last) st_d = (cnt_inc < MIN_C) ? SQ_PAD : SQ_FCS;
               end
            end
         end
         SQ_SKIP: begin
            if (in_valid && in_last) st_d = SQ_IDLE;
         end
         SQ_PAD: begin
            buf_we   = 1'b1;
            buf_addr = PRE_A + cnt[AW-1:0];
            crc_en   = 1'b1;
            crc_data = 8'h00;
            cnt_d    = cnt_inc;
            if (cnt_inc >= MIN_C) st_d = SQ_FCS;
         end
         SQ_FCS: begin
            buf_we    = 1'b1;
            buf_addr  = PRE_A + cnt[AW-1:0] + AW'(sub);
            buf_wdata = fcs[{sub[1:0], 3'b000} +: 8];
            sub_d     = sub + 1'b1;
            if (sub == SUB_W'(FCS_LEN - 1)) begin
               sub_d = '0;
               st_d  = SQ_PRE;
            end
         end
         SQ_PRE: begin
            buf_we    = 1'b1;
            buf_addr  = AW'(sub);
            buf_wdata = (sub == SUB_W'(PRE_LEN - 1)) ? PRE_SFD : PRE_FILL;
            sub_d     = sub + 1'b1;
            if (sub == SUB_W'(PRE_LEN - 1)) begin
               commit = 1'b1;
               st_d   = SQ_IDLE;
            end
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   assign buf_slot     = (st == SQ_IDLE) ? first_armed : slot_q;
   assign commit_slot  = slot_q;
   assign commit_count = cnt + TAIL_C;
   assign in_ready     = any_armed && (st == SQ_IDLE || st == SQ_BODY || st == SQ_SKIP);
endmodule

// File: rtl/rx_slot_assembler.sv
`timescale 1ns/1ps
module rx_slot_assembler
   import rxa_pkg::*;
#(
   parameter int SLOT_BYTES  = 2048,
   parameter int MIN_PAYLOAD = 60,
   parameter int NUM_SLOTS   = 2
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       in_valid,
   input  logic                                       in_first,
   input  logic                                       in_last,
   input  logic [7:0]                                 in_data,
   output logic                                       in_ready,
   input  logic                                       sw_we,
   input  logic [$clog2(NUM_SLOTS)-1:0]               sw_slot,
   input  logic [1:0]                                 sw_state,
   output logic                                       buf_we,
   output logic [$clog2(NUM_SLOTS)-1:0]               buf_slot,
   output logic [$clog2(SLOT_BYTES)-1:0]              buf_addr,
   output logic [7:0]                                 buf_wdata,
   output logic [2*NUM_SLOTS-1:0]                     slot_state,
   output logic [$clog2(SLOT_BYTES+1)*NUM_SLOTS-1:0]  slot_count,
   output logic                                       rx_irq
);
   localparam int SW = $clog2(NUM_SLOTS);
   localparam int AW = $clog2(SLOT_BYTES);
   localparam int CW = $clog2(SLOT_BYTES + 1);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("rx_slot_assembler: NUM_SLOTS must be at least 2");
   end
   if (SLOT_BYTES < PRE_LEN + MIN_PAYLOAD + FCS_LEN) begin : g_bad_size
      $error("rx_slot_assembler: SLOT_BYTES too small for a minimum frame");
   end
   if (MIN_PAYLOAD < 1) begin : g_bad_min
      $error("rx_slot_assembler: MIN_PAYLOAD must be positive");
   end

   logic          any_armed;
   logic [SW-1:0] first_armed;
   logic [31:0]   fcs;
   logic          crc_en, crc_restart;
   logic [7:0]    crc_data;
   logic          commit;
   logic [SW-1:0] commit_slot;
   logic [CW-1:0] commit_count;

   rxa_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .CW(CW), .SW(SW)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_we        (sw_we),
      .sw_slot      (sw_slot),
      .sw_state     (sw_state),
      .commit       (commit),
      .commit_slot  (commit_slot),
      .commit_count (commit_count),
      .slot_state   (slot_state),
      .slot_count   (slot_count),
      .any_armed    (any_armed),
      .first_armed  (first_armed),
      .irq          (rx_irq)
   );

   rxa_seq #(.SLOT_BYTES(SLOT_BYTES), .MIN_PAYLOAD(MIN_PAYLOAD),
             .SW(SW), .AW(AW), .CW(CW)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_first     (in_first),
      .in_last      (in_last),
      .in_data      (in_data),
      .any_armed    (any_armed),
      .first_armed  (first_armed),
      .fcs          (fcs),
      .in_ready     (in_ready),
      .buf_we       (buf_we),
      .buf_slot     (buf_slot),
      .buf_addr     (buf_addr),
      .buf_wdata    (buf_wdata),
      .crc_en       (crc_en),
      .crc_restart  (crc_restart),
      .crc_data     (crc_data),
      .commit       (commit),
      .commit_slot  (commit_slot),
      .commit_count (commit_count)
   );

   rxa_crc32 u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (crc_en),
      .restart (crc_restart),
      .data    (crc_data),
      .fcs     (fcs)
   );
endmodule

// File: rtl/rx_slot_assembler_chk.sv
`timescale 1ns/1ps
module rx_slot_assembler_chk
   import rxa_pkg::*;
#(
   parameter int SLOT_BYTES  = 2048,
   parameter int MIN_PAYLOAD = 60,
   parameter int NUM_SLOTS   = 2
) (
   input logic                                       clk,
   input logic                                       rst_n,
   input logic                                       sw_we,
   input logic [1:0]                                 sw_state,
   input logic                                       in_ready,
   input logic                                       buf_we,
   input logic [$clog2(NUM_SLOTS)-1:0]               buf_slot,
   input logic [$clog2(SLOT_BYTES)-1:0]              buf_addr,
   input logic [7:0]                                 buf_wdata,
   input logic [2*NUM_SLOTS-1:0]                     slot_state,
   input logic [$clog2(SLOT_BYTES+1)*NUM_SLOTS-1:0]  slot_count,
   input logic                                       rx_irq
);
   localparam int AW = $clog2(SLOT_BYTES);
   localparam int CW = $clog2(SLOT_BYTES + 1);

   logic any_armed;
   always_comb begin
      any_armed = 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++)
         if (slot_state[2*i +: 2] == SLOT_ARMED) any_armed = 1'b1;
   end

   // R10: the source is never invited while no slot is armed
   p_ready_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> any_armed);

   // R3: the first payload byte lands in a slot that is armed
   p_first_byte_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_addr == AW'(PRE_LEN)) |-> (slot_state[2*buf_slot +: 2] == SLOT_ARMED));

   // R4: preamble fill and delimiter bytes
   p_pre_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_addr < AW'(PRE_LEN - 1)) |-> (buf_wdata == PRE_FILL));
   p_pre_sfd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_addr == AW'(PRE_LEN - 1)) |-> (buf_wdata == PRE_SFD));

   // R9: the interrupt only rises after a software pending write or a frame completion
   p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq) |-> (($past(sw_we) && $past(sw_state) == SLOT_PENDING) ||
                         ($past(buf_we) && $past(buf_addr) == AW'(PRE_LEN - 1))));

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_chk
      // R6: a hardware completion leaves a count in the legal range
      p_pend_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_state[2*i +: 2] == SLOT_PENDING && $past(slot_state[2*i +: 2]) != SLOT_PENDING && !$past(sw_we))
         |-> (slot_count[CW*i +: CW] >= CW'(MIN_PAYLOAD + PRE_LEN + FCS_LEN) &&
              slot_count[CW*i +: CW] <= CW'(SLOT_BYTES)));
      // R7: a count only moves together with a completion
      p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(slot_count[CW*i +: CW]) |-> (slot_state[2*i +: 2] == SLOT_PENDING));
   end
endmodule

bind rx_slot_assembler rx_slot_assembler_chk #(
   .SLOT_BYTES(SLOT_BYTES), .MIN_PAYLOAD(MIN_PAYLOAD), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_we      (sw_we),
   .sw_state   (sw_state),
   .in_ready   (in_ready),
   .buf_we     (buf_we),
   .buf_slot   (buf_slot),
   .buf_addr   (buf_addr),
   .buf_wdata  (buf_wdata),
   .slot_state (slot_state),
   .slot_count (slot_count),
   .rx_irq     (rx_irq)
);

// File: tb/rx_slot_assembler_tb_top.sv
`timescale 1ns/1ps
module rx_slot_assembler_tb_top;
   localparam int SB = 2048;
   localparam int NS = 2;
   localparam int AW = 11;
   localparam int CW = 12;
   localparam int MAXP = SB - 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_ready;
   logic          sw_we = 1'b0;
   logic          sw_slot = 1'b0;
   logic [1:0]    sw_state = '0;
   logic          buf_we;
   logic          buf_slot;
   logic [AW-1:0] buf_addr;
   logic [7:0]    buf_wdata;
   logic [2*NS-1:0]  slot_state;
   logic [CW*NS-1:0] slot_count;
   logic          rx_irq;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct packed { logic s; logic [AW-1:0] a; logic [7:0] d; } wr_t;
   wr_t   exp_q[$];
   string tag_q[$];
   logic [7:0] pay [0:SB-1];

   always #10 clk = ~clk;

   rx_slot_assembler dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_last(in_last), .in_data(in_data), .in_ready(in_ready),
      .sw_we(sw_we), .sw_slot(sw_slot), .sw_state(sw_state),
      .buf_we(buf_we), .buf_slot(buf_slot), .buf_addr(buf_addr),
      .buf_wdata(buf_wdata), .slot_state(slot_state), .slot_count(slot_count),
      .rx_irq(rx_irq)
   );

   function automatic int get_state(input int s);
      return int'(slot_state[2*s +: 2]);
   endfunction
   function automatic int get_count(input int s);
      return int'(slot_count[CW*s +: CW]);
   endfunction

   function automatic logic [31:0] ref_fcs(input int n);
      logic [31:0] c;
      c = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++) begin
         for (int b = 0; b < 8; b++) begin
            logic fb;
            fb = c[0] ^ pay[i][b];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
         end
      end
      return ~c;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input int s, input int a, input logic [7:0] d, input string tag);
      exp_q.push_back('{s: 1'(s), a: AW'(a), d: d});
      tag_q.push_back(tag);
   endtask

   // monitor: every buffer write is compared with the scoreboard head
   wr_t   mon_e;
   string mon_t;
   always @(negedge clk) begin
      if (rst_n && buf_we) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R3 unexpected write actual=%0d/%0d/%h expected=none",
                     buf_slot, buf_addr, buf_wdata);
         end else begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            if ({buf_slot, buf_addr, buf_wdata} != mon_e) begin
               n_bad++;
               $display("FAIL %s write actual=%0d/%0d/%h expected=%0d/%0d/%h", mon_t,
                        buf_slot, buf_addr, buf_wdata, mon_e.s, mon_e.a, mon_e.d);
            end
         end
      end
   end

   task automatic sw_write(input int s, input int v);
      @(posedge clk); #1;
      sw_we = 1'b1; sw_slot = 1'(s); sw_state = 2'(v);
      @(posedge clk); #1;
      sw_we = 1'b0;
   endtask

   // mode 0: stored, mode 1: oversize, mode 2: no slot armed
   task automatic send_frame(input int len, input int seed, input int slot, input int mode);
      int plen, npad, old_cnt, old_st0, old_st1;
      logic [31:0] f;
      plen = (len < 60) ? 60 : len;
      npad = plen - len;
      old_cnt = get_count(slot);
      old_st0 = get_state(0);
      old_st1 = get_state(1);
      for (int i = 0; i < len; i++) pay[i] = 8'((seed + i * 13) ^ (i >> 3));
      for (int i = len; i < plen; i++) pay[i] = 8'h00;
      if (mode == 0) begin
         for (int i = 0; i < len; i++)  push(slot, 8 + i, pay[i], "R4");
         for (int i = len; i < plen; i++) push(slot, 8 + i, 8'h00, "R5");
         f = ref_fcs(plen);
         for (int k = 0; k < 4; k++) push(slot, 8 + plen + k, f[8*k +: 8], "R6");
         for (int k = 0; k < 8; k++) push(slot, k, (k == 7) ? 8'hD5 : 8'h55, "R4");
      end else if (mode == 1) begin
         for (int i = 0; i < MAXP; i++) push(slot, 8 + i, pay[i], "R7");
      end
      for (int i = 0; i < len; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b1; in_first = (i == 0); in_last = (i == len - 1); in_data = pay[i];
      end
      @(posedge clk); #1;
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
      if (mode == 0) begin
         @(negedge clk);
         chk("R10 ready low while finishing", int'(in_ready), 0);
         repeat (npad + 11) @(posedge clk);
         @(negedge clk);
         chk("R11 not committed one cycle early", get_state(slot), 1);
         @(posedge clk);
         @(negedge clk);
         chk("R8 state pending at commit", get_state(slot), 2);
         chk("R6 count is padded length plus 12", get_count(slot), plen + 12);
         chk("R8 irq high with pending slot", int'(rx_irq), 1);
      end else begin
         repeat (4) @(posedge clk);
         @(negedge clk);
         if (mode == 1) begin
            chk("R7 oversize slot stays loaded", get_state(slot), 1);
            chk("R7 oversize count unchanged", get_count(slot), old_cnt);
         end else begin
            chk("R3 no-slot frame leaves slot 0", get_state(0), old_st0);
            chk("R3 no-slot frame leaves slot 1", get_state(1), old_st1);
            chk("R3 no-slot frame raises no irq", int'(rx_irq), 0);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state 0", get_state(0), 0);
      chk("R1 reset state 1", get_state(1), 0);
      chk("R1 reset count 0", get_count(0), 0);
      chk("R1 reset count 1", get_count(1), 0);
      chk("R1 reset irq", int'(rx_irq), 0);
      chk("R1 reset ready", int'(in_ready), 0);

      send_frame(10, 3, 0, 2);

      sw_write(0, 1);
      sw_write(1, 1);
      @(negedge clk);
      chk("R2 slot 0 loaded", get_state(0), 1);
      chk("R2 slot 1 loaded", get_state(1), 1);
      chk("R10 ready with armed slot", int'(in_ready), 1);
      chk("R8 irq low with no pending", int'(rx_irq), 0);

      send_frame(20, 17, 0, 0);
      chk("R3 lowest slot used, slot 1 still loaded", get_state(1), 1);
      send_frame(100, 91, 1, 0);
      chk("R10 ready low with no armed slot", int'(in_ready), 0);

      sw_write(0, 0);
      @(negedge clk);
      chk("R9 irq stays high with slot 1 pending", int'(rx_irq), 1);
      sw_write(1, 0);
      @(negedge clk);
      chk("R9 irq drops after last pending cleared", int'(rx_irq), 0);
      sw_write(0, 2);
      @(negedge clk);
      chk("R9 irq rises on software pending write", int'(rx_irq), 1);
      sw_write(0, 0);

      sw_write(1, 1);
      send_frame(60, 200, 1, 0);
      sw_write(1, 0);

      sw_write(0, 1);
      send_frame(MAXP, 5, 0, 0);
      sw_write(0, 1);
      @(negedge clk);
      chk("R9 irq low after re-arm", int'(rx_irq), 0);
      send_frame(MAXP + 1, 77, 0, 1);
      chk("R7 oversize raises no irq", int'(rx_irq), 0);
      chk("R10 ready after discarded frame", int'(in_ready), 1);

      send_frame(1, 250, 0, 0);
      sw_write(1, 1);
      send_frame(64, 33, 1, 0);

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R4 all expected writes seen", exp_q.size(), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule